// File: doc/BRIEF.md
# Three-Format Instruction Word Decoder

This block takes one 16-bit instruction word, supplied as two bytes in fetch order, and works out which of three encoding formats it uses. It splits the word into an opcode, up to two register indices, an 8-bit immediate and a 10-bit branch offset, and it widens that offset into a signed byte displacement. It also reports the total instruction length in bytes and flags encodings that have no meaning. A fetch unit uses the length to know how many extension bytes follow. An execute stage uses the fields and the register-write indication.

The first format carries an 8-bit opcode and two register fields. The second carries a 2-bit opcode, one register and an 8-bit immediate. The third is the conditional branch, with a 4-bit condition opcode and a 10-bit halfword offset. The two top bits of the word select the format. The decode is combinational. A parameter adds one output register stage, which clears to zero on reset.

Top module: `insn_word_decoder`

## Requirements
- R1: Bit 15 = 0 gives format code 1, bits 15:14 = 2'b10 give format code 2, and bits 15:14 = 2'b11 give format code 3. A value of 0 never appears on the format output outside reset.
- R2: In format 1 the opcode output is bits 15:8, register A is bits 7:4 and register B is bits 3:0. The immediate, branch offset and displacement outputs are zero.
- R3: In format 2 the opcode output is bits 13:12 zero-extended, register A is bits 11:8 and the immediate is bits 7:0. Register B, the branch offset and the displacement are zero. The opcode values are 0 add immediate, 1 subtract immediate, 2 read special register and 3 write special register.
- R4: In format 3 the opcode output is bits 13:10 zero-extended and the branch offset is bits 9:0. The displacement is that offset sign-extended and doubled. Both registers and the immediate are zero.
- R5: Three cases flag the word illegal: format-1 opcodes 0x00, 0x16, 0x17, 0x18 and any above 0x39, and format-3 opcodes above 9. No format-2 word is illegal.
- R6: Format-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24 and 0x30 report a length of 6 bytes.
- R7: Format-1 opcodes 0x0C, 0x0D and 0x36 to 0x39 report a length of 4 bytes.
- R8: Every other word reports a length of 2 bytes, and that includes illegal words.
- R9: Register write is 0 in these cases: illegal words, all format-3 words, format-2 opcode 3, and format-1 opcodes 0x09, 0x0B, 0x0D, 0x0E, 0x0F, 0x1A, 0x1E, 0x1F, 0x23, 0x24, 0x25, 0x30, 0x35, 0x37 and 0x39. Register write is 1 for every other word. Opcode 0x0F is a legal no-op.
- R10: The first fetched byte forms bits 15:8 of the word and the second forms bits 7:0.
- R11: With the output register enabled (the default), the outputs show the decode of the bytes present at the previous rising clock edge. While reset is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_first | input | 8 | First fetched instruction byte |
| byte_second | input | 8 | Second fetched instruction byte |
| fmt_o | output | 2 | Format code 1, 2 or 3 |
| opcode_o | output | 8 | Opcode, zero-extended |
| reg_a_o | output | 4 | First register index |
| reg_b_o | output | 4 | Second register index |
| imm8_o | output | 8 | Format-2 immediate |
| br_off_o | output | 10 | Raw branch offset field |
| br_disp_o | output | DISP_W | Signed byte displacement of a branch |
| len_o | output | 3 | Instruction length in bytes |
| illegal_o | output | 1 | Encoding has no meaning |
| reg_wr_o | output | 1 | Instruction writes a general register |

## Verification
The assertions assume that both byte inputs hold known values at every rising edge after reset. They also assume that the output register is enabled when they compare an output with the bytes of the previous edge. The stimulus changes the bytes only on falling edges and never leaves them undriven once reset has been released. The vectors cover every format, the edges of each illegal range and each length class, and the branch offsets at both extremes and at minus one.

// File: rtl/insdec_pkg.sv
package insdec_pkg;

  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int OPC_W   = 8;
  localparam int REG_W   = 4;
  localparam int IMM_W   = 8;
  localparam int BOFF_W  = 10;
  localparam int LEN_W   = 3;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_ONE   = 2'd1,
    FMT_TWO   = 2'd2,
    FMT_THREE = 2'd3
  } fmt_e;

  // Format-1 opcode is illegal: zero, the hole at 0x16..0x18, or past 0x39.
  function automatic logic f1_illegal(input logic [OPC_W-1:0] op);
    return (op == 8'h00) || (op >= 8'h16 && op <= 8'h18) || (op > 8'h39);
  endfunction

  // Number of extension bytes that follow a format-1 word.
  function automatic logic [LEN_W-1:0] f1_ext_bytes(input logic [OPC_W-1:0] op);
    logic [LEN_W-1:0] n;
    unique case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h1A, 8'h1B,
      8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30: n = 3'd4;
      8'h0C, 8'h0D, 8'h36, 8'h37, 8'h38, 8'h39:  n = 3'd2;
      default:                                   n = 3'd0;
    endcase
    return n;
  endfunction

  // Format-1 opcodes that leave every general register untouched here.
  function automatic logic f1_no_write(input logic [OPC_W-1:0] op);
    logic r;
    unique case (op)
      8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h0F, 8'h1A, 8'h1E, 8'h1F,
      8'h23, 8'h24, 8'h25, 8'h30, 8'h35, 8'h37, 8'h39: r = 1'b1;
      default:                                         r = 1'b0;
    endcase
    return r;
  endfunction

  // Branch condition code beyond the defined set.
  function automatic logic f3_illegal(input logic [3:0] cond);
    return cond > 4'd9;
  endfunction

endpackage

// File: rtl/insdec_split.sv
module insdec_split
  import insdec_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic [BYTE_W-1:0] byte_first,
  input  logic [BYTE_W-1:0] byte_second,
  output fmt_e              fmt,
  output logic [OPC_W-1:0]  opcode,
  output logic [REG_W-1:0]  reg_a,
  output logic [REG_W-1:0]  reg_b,
  output logic [IMM_W-1:0]  imm8,
  output logic [BOFF_W-1:0] br_off,
  output logic [DISP_W-1:0] br_disp
);

  localparam int SEXT_W = DISP_W - BOFF_W - 1;

  logic [WORD_W-1:0] word;
  assign word = {byte_first, byte_second};

  function automatic logic [DISP_W-1:0] widen_offset(input logic [BOFF_W-1:0] off);
    return {{SEXT_W{off[BOFF_W-1]}}, off, 1'b0};
  endfunction

  always_comb begin
    fmt     = FMT_ONE;
    opcode  = '0;
    reg_a   = '0;
    reg_b   = '0;
    imm8    = '0;
    br_off  = '0;
    br_disp = '0;
    if (!word[15]) begin
      fmt    = FMT_ONE;
      opcode = word[15:8];
      reg_a  = word[7:4];
      reg_b  = word[3:0];
    end else if (!word[14]) begin
      fmt    = FMT_TWO;
      opcode = {6'b0, word[13:12]};
      reg_a  = word[11:8];
      imm8   = word[7:0];
    end else begin
      fmt     = FMT_THREE;
      opcode  = {4'b0, word[13:10]};
      br_off  = word[9:0];
      br_disp = widen_offset(word[9:0]);
    end
  end

endmodule

// File: rtl/insdec_classify.sv
module insdec_classify
  import insdec_pkg::*;
(
  input  fmt_e             fmt,
  input  logic [OPC_W-1:0] opcode,
  output logic [LEN_W-1:0] len,
  output logic             illegal,
  output logic             reg_wr
);

  localparam logic [LEN_W-1:0] BASE_LEN = 3'd2;

  always_comb begin
    len     = BASE_LEN;
    illegal = 1'b0;
    reg_wr  = 1'b0;
    unique case (fmt)
      FMT_ONE: begin
        illegal = f1_illegal(opcode);
        len     = BASE_LEN + (illegal ? 3'd0 : f1_ext_bytes(opcode));
        reg_wr  = !illegal && !f1_no_write(opcode);
      end
      FMT_TWO: begin
        reg_wr = (opcode[1:0] != 2'd3);
      end
      FMT_THREE: begin
        illegal = f3_illegal(opcode[3:0]);
      end
      default: begin
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/insdec_stage.sv
module insdec_stage #(
  parameter bit REG_OUT = 1'b1,
  parameter int W       = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         live
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_pass
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/insn_word_decoder.sv
module insn_word_decoder
  import insdec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int DISP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        byte_first,
  input  logic [7:0]        byte_second,
  output logic [1:0]        fmt_o,
  output logic [7:0]        opcode_o,
  output logic [3:0]        reg_a_o,
  output logic [3:0]        reg_b_o,
  output logic [7:0]        imm8_o,
  output logic [9:0]        br_off_o,
  output logic [DISP_W-1:0] br_disp_o,
  output logic [2:0]        len_o,
  output logic              illegal_o,
  output logic              reg_wr_o
);

  localparam int PACK_W = 2 + OPC_W + 2*REG_W + IMM_W + BOFF_W + DISP_W + LEN_W + 2;

  fmt_e              dec_fmt;
  logic [OPC_W-1:0]  dec_opc;
  logic [REG_W-1:0]  dec_ra, dec_rb;
  logic [IMM_W-1:0]  dec_imm;
  logic [BOFF_W-1:0] dec_boff;
  logic [DISP_W-1:0] dec_disp;
  logic [LEN_W-1:0]  dec_len;
  logic              dec_ill, dec_wr;
  logic              out_live;

  insdec_split #(.DISP_W(DISP_W)) u_split (
    .byte_first (byte_first),
    .byte_second(byte_second),
    .fmt        (dec_fmt),
    .opcode     (dec_opc),
    .reg_a      (dec_ra),
    .reg_b      (dec_rb),
    .imm8       (dec_imm),
    .br_off     (dec_boff),
    .br_disp    (dec_disp)
  );

  insdec_classify u_class (
    .fmt    (dec_fmt),
    .opcode (dec_opc),
    .len    (dec_len),
    .illegal(dec_ill),
    .reg_wr (dec_wr)
  );

  insdec_stage #(.REG_OUT(REG_OUT), .W(PACK_W)) u_stage (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({dec_fmt, dec_opc, dec_ra, dec_rb, dec_imm, dec_boff, dec_disp,
            dec_len, dec_ill, dec_wr}),
    .q    ({fmt_o, opcode_o, reg_a_o, reg_b_o, imm8_o, br_off_o, br_disp_o,
            len_o, illegal_o, reg_wr_o}),
    .live (out_live)
  );

  // Output-level consistency between the split and classify paths.
  assert_fmt_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_live |-> fmt_o != 2'd0);

  assert_illegal_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && illegal_o) |-> (len_o == 3'd2 && !reg_wr_o));

  assert_ext_only_f1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && len_o != 3'd2) |-> fmt_o == 2'd1);

  assert_branch_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && fmt_o == 2'd3) |-> (reg_a_o == '0 && reg_b_o == '0 &&
                                     imm8_o == '0 && !reg_wr_o));

  assert_f2_never_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && fmt_o == 2'd2) |-> !illegal_o);

  assert_sreg_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && fmt_o == 2'd2 && opcode_o == 8'd3) |-> !reg_wr_o);

  generate
    if (REG_OUT) begin : g_lat_chk
      assert_latency_fmt1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live && !$past(byte_first[7])) |-> fmt_o == 2'd1);
      assert_latency_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_live && !$past(byte_first[7])) |->
          (opcode_o == $past(byte_first) && reg_b_o == $past(byte_second[3:0])));
    end
  endgenerate

endmodule

// File: tb/insn_word_decoder_tb.sv
module insn_word_decoder_tb;

  localparam int DW = 16;
  localparam int NV = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] b1 = '0, b2 = '0;
  logic [1:0] fmt;
  logic [7:0] opc, imm;
  logic [3:0] ra, rb;
  logic [9:0] boff;
  logic [DW-1:0] disp;
  logic [2:0] len;
  logic ill, wr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  insn_word_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .byte_first(b1), .byte_second(b2),
    .fmt_o(fmt), .opcode_o(opc), .reg_a_o(ra), .reg_b_o(rb), .imm8_o(imm),
    .br_off_o(boff), .br_disp_o(disp), .len_o(len), .illegal_o(ill),
    .reg_wr_o(wr)
  );

  // {word, fmt, len, illegal, write}
  localparam logic [22:0] VEC [0:NV-1] = '{
    {16'h0000, 2'd1, 3'd2, 1'b1, 1'b0},
    {16'h0123, 2'd1, 3'd6, 1'b0, 1'b1},
    {16'h0345, 2'd1, 3'd6, 1'b0, 1'b1},
    {16'h0C12, 2'd1, 3'd4, 1'b0, 1'b1},
    {16'h0D12, 2'd1, 3'd4, 1'b0, 1'b0},
    {16'h0F00, 2'd1, 3'd2, 1'b0, 1'b0},
    {16'h0E12, 2'd1, 3'd2, 1'b0, 1'b0},
    {16'h1500, 2'd1, 3'd2, 1'b0, 1'b1},
    {16'h1600, 2'd1, 3'd2, 1'b1, 1'b0},
    {16'h1800, 2'd1, 3'd2, 1'b1, 1'b0},
    {16'h1900, 2'd1, 3'd2, 1'b0, 1'b1},
    {16'h1A00, 2'd1, 3'd6, 1'b0, 1'b0},
    {16'h1F45, 2'd1, 3'd6, 1'b0, 1'b0},
    {16'h2456, 2'd1, 3'd6, 1'b0, 1'b0},
    {16'h3000, 2'd1, 3'd6, 1'b0, 1'b0},
    {16'h3500, 2'd1, 3'd2, 1'b0, 1'b0},
    {16'h3678, 2'd1, 3'd4, 1'b0, 1'b1},
    {16'h3978, 2'd1, 3'd4, 1'b0, 1'b0},
    {16'h3A00, 2'd1, 3'd2, 1'b1, 1'b0},
    {16'h7F00, 2'd1, 3'd2, 1'b1, 1'b0},
    {16'h8512, 2'd2, 3'd2, 1'b0, 1'b1},
    {16'h9FFF, 2'd2, 3'd2, 1'b0, 1'b1},
    {16'hA3C0, 2'd2, 3'd2, 1'b0, 1'b1},
    {16'hB7FF, 2'd2, 3'd2, 1'b0, 1'b0},
    {16'hC3FF, 2'd3, 3'd2, 1'b0, 1'b0},
    {16'hE5FF, 2'd3, 3'd2, 1'b0, 1'b0},
    {16'hE800, 2'd3, 3'd2, 1'b1, 1'b0},
    {16'hFC00, 2'd3, 3'd2, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    b1 = w[15:8];
    b2 = w[7:0];
    @(posedge clk);
    #5;
  endtask

  // Field expectations restated from R2..R4, R10.
  task automatic check_fields(input logic [15:0] w);
    logic [7:0] e_opc, e_imm;
    logic [3:0] e_ra, e_rb;
    logic [9:0] e_off;
    logic [DW-1:0] e_disp;
    e_opc = 0; e_imm = 0; e_ra = 0; e_rb = 0; e_off = 0; e_disp = 0;
    if (w[15] == 1'b0) begin
      e_opc = w[15:8]; e_ra = w[7:4]; e_rb = w[3:0];
    end else if (w[14] == 1'b0) begin
      e_opc = 8'(w[13:12]); e_ra = w[11:8]; e_imm = w[7:0];
    end else begin
      e_opc = 8'(w[13:10]); e_off = w[9:0];
      e_disp = DW'($signed(w[9:0])) * 2;
    end
    chk(opc == e_opc, "R2/R3/R4 opcode R10", opc, e_opc);
    chk(ra == e_ra && rb == e_rb, "R2/R3 registers", {ra, rb}, {e_ra, e_rb});
    chk(imm == e_imm, "R3 immediate", imm, e_imm);
    chk(boff == e_off && disp == e_disp, "R4 branch", {boff, disp}, {e_off, e_disp});
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    b1 = 8'h01; b2 = 8'h23;
    repeat (3) @(posedge clk);
    #5;
    // R11: reset holds every output at zero
    chk({fmt, opc, ra, rb, imm, boff, disp, len, ill, wr} == '0, "R11 reset zero",
        {fmt, len, ill, wr}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] w;
      w = VEC[i][22:7];
      apply(w);
      chk(fmt == VEC[i][6:5], "R1 format", fmt, VEC[i][6:5]);
      chk(len == VEC[i][4:2], "R6/R7/R8 length", len, VEC[i][4:2]);
      chk(ill == VEC[i][1], "R5 illegal", ill, VEC[i][1]);
      chk(wr == VEC[i][0], "R9 write enable", wr, VEC[i][0]);
      check_fields(w);
    end

    // R4: offset extremes
    apply(16'hC200);
    chk(disp == 16'hFC00, "R4 most negative disp", disp, 16'hFC00);
    apply(16'hC1FF);
    chk(disp == 16'h03FE, "R4 most positive disp", disp, 16'h03FE);
    apply(16'hC3FF);
    chk(disp == 16'hFFFE, "R4 minus one disp", disp, 16'hFFFE);

    // R10: byte order, swapped bytes give a different word
    apply(16'h2301);
    chk(opc == 8'h23 && ra == 4'h0 && rb == 4'h1, "R10 first byte high",
        {opc, ra, rb}, {8'h23, 4'h0, 4'h1});

    // R11: one-cycle latency, old decode visible before the edge
    apply(16'h0123);
    @(negedge clk);
    b1 = 8'hB7; b2 = 8'hFF;
    #2;
    chk(fmt == 2'd1 && len == 3'd6, "R11 holds previous", {fmt, len}, {2'd1, 3'd6});
    @(posedge clk);
    #5;
    chk(fmt == 2'd2 && wr == 1'b0, "R11 updates after edge", {fmt, wr}, {2'd2, 1'b0});

    // R11: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk({fmt, opc, ra, imm, len, wr} == '0, "R11 reset clears", {fmt, opc}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(16'h0F00);
    chk(ill == 1'b0 && wr == 1'b0 && len == 3'd2, "R9 no-op legal quiet",
        {ill, wr, len}, {1'b0, 1'b0, 3'd2});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule